// File: doc/BRIEF.md
# PWM Ramp Timer with Sync, Sample and Interrupt Triggers

This block is the period timebase of one PWM channel. A free-running ramp counter runs over a programmed period. The counter value is compared against programmed positions to produce three kinds of event. The first is a fixed-width sync output pulse that neighbouring channels can lock to. The second is one or more ADC sample triggers per period. The third is a periodic CPU interrupt divided down over several switching periods.

An incoming sync pulse restarts the ramp at zero. Chaining one channel's sync output into another channel's sync input, with a chosen threshold, sets the phase offset between interleaved power stages. The sample trigger fires either once, at a programmed position, or 2, 4 or 8 times at evenly spaced points of the period. The interrupt divider counts period ends and fires once every N periods, where N comes from a fixed table of 15 settings. The same pulse can be routed out as the start signal for an ADC sequencer.

Software writes four registers over a simple parallel write bus. Address 0 holds the period, 1 the sync threshold, 2 the single-sample position, and 3 the control word. The control word has these fields: bits [1:0] oversample code, bits [5:2] interrupt divide setting, bit 6 sequencer route, bit 7 run enable.

Top module: `ramp_timer`

## Requirements
- R1: While the run enable (control bit 7) is set, `ramp_cnt` counts 0, 1, … P−1 and then returns to 0, where P is the effective period. While the enable is clear, the counter is held at 0.
- R2: A programmed period below 8 behaves as a period of 8.
- R3: Writes to period, threshold, sample position, oversample code and divide setting take effect only at the end of the current period (natural wrap or sync restart). While the enable is clear, they take effect immediately.
- R4: When `sync_in` is high in a running cycle, the counter is 0 in the next cycle. The event counts as a period end.
- R5: `sync_out` goes high in the cycle after the counter equals the threshold and stays high for exactly 64 cycles (SYNC_PULSE).
- R6: With oversample code 0, `adc_trig` pulses for one cycle in the cycle after the counter equals the sample position.
- R7: With oversample codes 1, 2 and 3, `adc_trig` pulses N = 2, 4 or 8 times per period. The pulses come one cycle after the counter equals j·floor(P/N), for j = 0 … N−1.
- R8: With divide setting s = 1 … 15, `irq` pulses once, in the cycle after every N-th period end. N runs 1, 2, 4, 8, 16, 32, 48, 64, 80, 96, 128, 160, 192, 224, 256 for these settings. Setting 0 gives no interrupt.
- R9: `seq_trig` pulses together with `irq` when control bit 6 is set, and stays low otherwise.
- R10: After reset the counter is 0 and all trigger outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Register write data |
| sync_in | input | 1 | Ramp restart request |
| ramp_cnt | output | 16 | Current ramp count |
| sync_out | output | 1 | Phase sync pulse |
| adc_trig | output | 1 | ADC sample trigger |
| irq | output | 1 | Divided period interrupt |
| seq_trig | output | 1 | ADC sequencer start |

## Verification
The bench writes the period mid-ramp and checks where the current period still ends. A design that loaded the new period at once would stretch or cut that period. A period of 42 with four-way oversampling leaves a remainder, so a design that wrapped its sub-step counter by modulo, or counted triggers past N, would fire a fifth trigger at 40. Divide settings 3, 7 and 15 check the irregular steps of the table, where a plain power-of-two decode gives the wrong spacing. A sync restart with divide setting 1 shows whether the restart is counted as a period end for the interrupt. Periods below 8 and sync pulses longer than the period probe the clamp and the retrigger behaviour.

// File: rtl/ramp_pkg.sv
// Shared definitions for the ramp timer: register addresses, oversample
// modes and the interrupt divide decode.
package ramp_pkg;

    localparam logic [1:0] ADDR_PERIOD = 2'd0;
    localparam logic [1:0] ADDR_THRESH = 2'd1;
    localparam logic [1:0] ADDR_SAMPLE = 2'd2;
    localparam logic [1:0] ADDR_CTRL   = 2'd3;

    typedef enum logic [1:0] {
        OS_X1 = 2'd0,
        OS_X2 = 2'd1,
        OS_X4 = 2'd2,
        OS_X8 = 2'd3
    } os_mode_t;

    // Number of switching periods per interrupt for a divide setting.
    function automatic logic [8:0] div_periods(input logic [3:0] s);
        logic [8:0] sx;
        sx = {5'd0, s};
        if (s == 4'd0)
            return 9'd0;
        else if (s <= 4'd6)
            return 9'd1 << (sx - 9'd1);
        else if (s <= 4'd10)
            return (sx - 9'd4) << 4;
        else
            return (sx - 9'd7) << 5;
    endfunction

endpackage

// File: rtl/ramp_regs.sv
// Register file for the ramp timer. Each register has a pending copy that
// the bus writes and an active copy used by the timer. Active copies load
// when 'load' is high (period end, or timer stopped). Run enable and
// sequencer route apply at once. Assumes one write per cycle at most.
module ramp_regs
    import ramp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             load,
    output logic [CNT_W-1:0] per_act,
    output logic [CNT_W-1:0] thr_act,
    output logic [CNT_W-1:0] samp_act,
    output os_mode_t         os_act,
    output logic [3:0]       div_act,
    output logic             route,
    output logic             run
);

    logic [CNT_W-1:0] per_pend, thr_pend, samp_pend;
    os_mode_t         os_pend;
    logic [3:0]       div_pend;

    // Capture bus writes into the pending copies and immediate control bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_pend  <= '0;
            thr_pend  <= '0;
            samp_pend <= '0;
            os_pend   <= OS_X1;
            div_pend  <= '0;
            route     <= 1'b0;
            run       <= 1'b0;
        end else if (wr_en) begin
            case (wr_addr)
                ADDR_PERIOD: per_pend  <= wr_data;
                ADDR_THRESH: thr_pend  <= wr_data;
                ADDR_SAMPLE: samp_pend <= wr_data;
                default: begin
                    os_pend  <= os_mode_t'(wr_data[1:0]);
                    div_pend <= wr_data[5:2];
                    route    <= wr_data[6];
                    run      <= wr_data[7];
                end
            endcase
        end
    end

    // Transfer pending values to the active copies at the load point.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_act  <= '0;
            thr_act  <= '0;
            samp_act <= '0;
            os_act   <= OS_X1;
            div_act  <= '0;
        end else if (load) begin
            per_act  <= per_pend;
            thr_act  <= thr_pend;
            samp_act <= samp_pend;
            os_act   <= os_pend;
            div_act  <= div_pend;
        end
    end

    assert_shadow_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(per_act) && $stable(thr_act) && $stable(samp_act));

endmodule

// File: rtl/ramp_counter.sv
// Ramp counter: counts 0..P-1 while running, restarts on sync_in, and
// holds 0 while stopped. Periods below MIN_PER are raised to MIN_PER.
// 'wrap' flags the last cycle of a period (natural or sync restart).
module ramp_counter #(
    parameter int CNT_W   = 16,
    parameter int MIN_PER = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             sync_in,
    input  logic [CNT_W-1:0] per_act,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] per_eff,
    output logic             wrap
);

    localparam logic [CNT_W-1:0] MIN_P = CNT_W'(MIN_PER);

    // Effective period after the lower clamp, and the period-end flag.
    always_comb begin
        per_eff = (per_act < MIN_P) ? MIN_P : per_act;
        wrap    = run && (sync_in || (cnt == per_eff - 1'b1));
    end

    // Advance, wrap or clear the ramp.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run || wrap)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assert_cnt_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> cnt < per_eff);
    assert_hold_stopped_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> cnt == '0);
    assert_sync_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        run && sync_in |=> cnt == '0);

endmodule

// File: rtl/ramp_sync_gen.sv
// Sync output generator: starts a PULSE-cycle pulse in the cycle after the
// ramp equals the threshold. A new match restarts the pulse.
module ramp_sync_gen #(
    parameter int CNT_W = 16,
    parameter int PULSE = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] thr,
    output logic             sync_out
);

    localparam int SC_W = $clog2(PULSE + 1);
    localparam logic [SC_W-1:0] PULSE_V = SC_W'(PULSE);

    logic [SC_W-1:0] left;

    // Load the pulse length on a match, otherwise count down.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            left <= '0;
        else if (cnt == thr)
            left <= PULSE_V;
        else if (left != '0)
            left <= left - 1'b1;
    end

    assign sync_out = (left != '0);

    assert_sync_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_out) |-> $past(cnt == thr) && $past(run));

endmodule

// File: rtl/ramp_sample_trig.sv
// ADC sample trigger. Code X1 fires once, one cycle after the ramp equals
// the sample position. Codes X2/X4/X8 split the period into N steps of
// floor(P/N) with a sub-step counter and fire at the start of each of the
// first N steps; the remainder extends the last step.
module ramp_sample_trig
    import ramp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             wrap,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] per_eff,
    input  logic [CNT_W-1:0] samp,
    input  os_mode_t         os,
    output logic             trig
);

    logic [CNT_W-1:0] step;
    logic [3:0]       n_trig;
    logic [CNT_W-1:0] sub;
    logic [3:0]       idx;
    logic             fire;

    // Step length, trigger count and the fire decision for this cycle.
    always_comb begin
        step   = per_eff >> os;
        n_trig = 4'd1 << os;
        if (os == OS_X1)
            fire = (cnt == samp);
        else
            fire = (sub == '0) && (idx < n_trig);
    end

    // Step through the period and register the trigger.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            sub  <= '0;
            idx  <= '0;
            trig <= 1'b0;
        end else begin
            trig <= fire;
            if (wrap) begin
                sub <= '0;
                idx <= '0;
            end else if (sub == step - 1'b1) begin
                sub <= '0;
                if (idx < n_trig)
                    idx <= idx + 1'b1;
            end else begin
                sub <= sub + 1'b1;
            end
        end
    end

    assert_single_pos_R6: assert property (@(posedge clk) disable iff (!rst_n)
        trig && $past(os == OS_X1) |-> $past(cnt == samp));
    assert_trig_running_R7: assert property (@(posedge clk) disable iff (!rst_n)
        trig |-> $past(run));

endmodule

// File: rtl/ramp_irq_div.sv
// Interrupt divider: counts period ends and pulses irq after the N-th one,
// N taken from the divide table. Setting 0 disables the interrupt. The
// same pulse goes to seq_trig when route is set.
module ramp_irq_div
    import ramp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       wrap,
    input  logic [3:0] div,
    input  logic       route,
    output logic       irq,
    output logic       seq_trig
);

    logic [8:0] periods;
    logic [8:0] seen;
    logic       hit;

    // Decode the divide setting and detect the N-th period end.
    always_comb begin
        periods = div_periods(div);
        hit     = wrap && (div != 4'd0) && (seen >= periods - 9'd1);
    end

    // Count period ends and register the interrupt and sequencer pulses.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            seen     <= '0;
            irq      <= 1'b0;
            seq_trig <= 1'b0;
        end else begin
            irq      <= hit;
            seq_trig <= hit && route;
            if (hit || div == 4'd0)
                seen <= '0;
            else if (wrap)
                seen <= seen + 9'd1;
        end
    end

    assert_irq_on_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(wrap));
    assert_seq_with_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        seq_trig |-> irq);

endmodule

// File: rtl/ramp_timer.sv
// Top of the PWM ramp timer. Ties the register file, ramp counter, sync
// output, sample trigger and interrupt divider together. Shadowed values
// load at each period end, or continuously while the timer is stopped.
module ramp_timer #(
    parameter int CNT_W      = 16,
    parameter int SYNC_PULSE = 64,
    parameter int MIN_PERIOD = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [CNT_W-1:0] bus_wdata,
    input  logic             sync_in,
    output logic [CNT_W-1:0] ramp_cnt,
    output logic             sync_out,
    output logic             adc_trig,
    output logic             irq,
    output logic             seq_trig
);

    import ramp_pkg::*;

    logic [CNT_W-1:0] per_act, thr_act, samp_act, per_eff;
    os_mode_t         os_act;
    logic [3:0]       div_act;
    logic             route, run, wrap, load;

    assign load = wrap || !run;

    ramp_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(bus_wr), .wr_addr(bus_addr), .wr_data(bus_wdata),
        .load(load),
        .per_act(per_act), .thr_act(thr_act), .samp_act(samp_act),
        .os_act(os_act), .div_act(div_act), .route(route), .run(run)
    );

    ramp_counter #(.CNT_W(CNT_W), .MIN_PER(MIN_PERIOD)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run(run), .sync_in(sync_in),
        .per_act(per_act), .cnt(ramp_cnt), .per_eff(per_eff), .wrap(wrap)
    );

    ramp_sync_gen #(.CNT_W(CNT_W), .PULSE(SYNC_PULSE)) u_sync (
        .clk(clk), .rst_n(rst_n), .run(run),
        .cnt(ramp_cnt), .thr(thr_act), .sync_out(sync_out)
    );

    ramp_sample_trig #(.CNT_W(CNT_W)) u_samp (
        .clk(clk), .rst_n(rst_n), .run(run), .wrap(wrap),
        .cnt(ramp_cnt), .per_eff(per_eff), .samp(samp_act),
        .os(os_act), .trig(adc_trig)
    );

    ramp_irq_div u_irq (
        .clk(clk), .rst_n(rst_n), .run(run), .wrap(wrap),
        .div(div_act), .route(route), .irq(irq), .seq_trig(seq_trig)
    );

endmodule

// File: tb/test_ramp_timer.sv
module test_ramp_timer;

    localparam int CLK_PERIOD = 10;
    localparam int PULSE      = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        sync_in = 1'b0;
    logic [15:0] ramp_cnt;
    logic        sync_out, adc_trig, irq, seq_trig;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    int m_per, m_thr, m_samp, m_os, m_div, m_route;

    ramp_timer i_ramp_timer (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .sync_in(sync_in), .ramp_cnt(ramp_cnt),
        .sync_out(sync_out), .adc_trig(adc_trig), .irq(irq), .seq_trig(seq_trig)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input int d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = 16'(d);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    function automatic int div_n(input int s);
        if (s == 0) return 0;
        if (s <= 6) return 1 << (s - 1);
        if (s <= 10) return (s - 4) * 16;
        return (s - 7) * 32;
    endfunction

    // Stop, program everything, then start the timer.
    task automatic start(input int per, input int thr, input int samp,
                         input int os, input int dv, input int route);
        int ctl;
        m_per = per; m_thr = thr; m_samp = samp; m_os = os; m_div = dv; m_route = route;
        ctl = os | (dv << 2) | (route << 6);
        wr(2'd3, ctl);
        wr(2'd0, per);
        wr(2'd1, thr);
        wr(2'd2, samp);
        wr(2'd3, ctl);
        wr(2'd3, ctl | 128);
    endtask

    // Run n cycles comparing every output against the bench model.
    task automatic observe(input int n, input string cnt_req, input string trig_req);
        int prev, pe, step, rem, wc, nd;
        int e_cnt, e_trig, e_sync, e_irq, e_seq;
        int a_cnt, a_trig, a_sync, a_irq, a_seq;
        int x_cnt, x_trig, x_sync, x_irq, x_seq;
        bit ec, et, es, ei, eq;
        e_cnt = 0; e_trig = 0; e_sync = 0; e_irq = 0; e_seq = 0;
        a_cnt = 0; a_trig = 0; a_sync = 0; a_irq = 0; a_seq = 0;
        x_cnt = 0; x_trig = 0; x_sync = 0; x_irq = 0; x_seq = 0;
        pe = (m_per < 8) ? 8 : m_per;
        nd = div_n(m_div);
        rem = 0; wc = 0;
        prev = int'(ramp_cnt);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            ec = (int'(ramp_cnt) == ((prev == pe - 1) ? 0 : prev + 1));
            if (m_os == 0) et = (prev == m_samp);
            else begin
                step = pe >> m_os;
                et = (prev % step == 0) && (prev / step < (1 << m_os));
            end
            if (prev == m_thr) rem = PULSE;
            es = (rem > 0);
            if (rem > 0) rem--;
            ei = (nd != 0) && (prev == pe - 1) && (wc >= nd - 1);
            if (prev == pe - 1) wc = ei ? 0 : wc + 1;
            eq = ei && (m_route != 0);
            if (!ec) begin e_cnt++; a_cnt = int'(ramp_cnt); x_cnt = (prev == pe - 1) ? 0 : prev + 1; end
            if (adc_trig != et) begin e_trig++; a_trig = adc_trig; x_trig = et; end
            if (sync_out != es) begin e_sync++; a_sync = sync_out; x_sync = es; end
            if (irq != ei) begin e_irq++; a_irq = irq; x_irq = ei; end
            if (seq_trig != eq) begin e_seq++; a_seq = seq_trig; x_seq = eq; end
            prev = int'(ramp_cnt);
        end
        check(e_cnt == 0, {cnt_req, " ramp count"}, a_cnt, x_cnt);
        check(e_trig == 0, {trig_req, " adc_trig"}, a_trig, x_trig);
        check(e_sync == 0, "R5 sync_out", a_sync, x_sync);
        check(e_irq == 0, "R8 irq", a_irq, x_irq);
        check(e_seq == 0, "R9 seq_trig", a_seq, x_seq);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(ramp_cnt == 0 && !sync_out && !adc_trig && !irq && !seq_trig,
              "R10 reset state", int'(ramp_cnt), 0);
    endtask

    task automatic t_basic();
        start(10, 3, 7, 0, 1, 1);
        observe(200, "R1", "R6");
        start(30, 29, 0, 0, 2, 1);
        observe(200, "R1", "R6");
    endtask

    task automatic t_oversample();
        start(40, 5, 0, 1, 0, 0);
        observe(120, "R1", "R7 x2");
        start(40, 5, 0, 2, 0, 0);
        observe(120, "R1", "R7 x4");
        start(40, 5, 0, 3, 0, 0);
        observe(120, "R1", "R7 x8");
        start(42, 5, 0, 2, 0, 0);
        observe(130, "R1", "R7 x4 odd period");
    endtask

    task automatic t_irq_div();
        start(8, 0, 2, 0, 3, 1);
        observe(100, "R1", "R6");
        start(8, 0, 2, 0, 7, 1);
        observe(500, "R1", "R6");
        start(8, 0, 2, 0, 15, 1);
        observe(2100, "R1", "R6");
        start(8, 0, 2, 0, 0, 1);
        observe(100, "R1", "R6");
        start(8, 0, 2, 0, 1, 0);
        observe(100, "R1", "R6");
    endtask

    task automatic t_clamp();
        start(3, 1, 6, 0, 1, 0);
        observe(60, "R2", "R2");
    endtask

    task automatic t_shadow();
        int mx;
        start(10, 200, 200, 0, 0, 0);
        while (ramp_cnt != 4) @(negedge clk);
        wr(2'd0, 16);
        mx = 0;
        while (ramp_cnt != 0) begin
            if (int'(ramp_cnt) > mx) mx = int'(ramp_cnt);
            @(negedge clk);
        end
        check(mx == 9, "R3 old period kept until wrap", mx, 9);
        @(negedge clk);
        mx = 0;
        while (ramp_cnt != 0) begin
            if (int'(ramp_cnt) > mx) mx = int'(ramp_cnt);
            @(negedge clk);
        end
        check(mx == 15, "R3 new period after wrap", mx, 15);
    endtask

    task automatic t_sync_in();
        start(50, 200, 200, 0, 1, 1);
        while (ramp_cnt != 20) @(negedge clk);
        sync_in = 1'b1;
        @(negedge clk);
        sync_in = 1'b0;
        check(ramp_cnt == 0, "R4 sync restart", int'(ramp_cnt), 0);
        check(irq == 1'b1, "R4 sync counts as period end", int'(irq), 1);
        @(negedge clk);
        check(ramp_cnt == 1, "R4 counting resumes", int'(ramp_cnt), 1);
    endtask

    task automatic t_stop();
        wr(2'd3, 0);
        repeat (3) @(negedge clk);
        check(ramp_cnt == 0 && !adc_trig && !irq, "R1 held while stopped", int'(ramp_cnt), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_oversample();
        t_irq_div();
        t_clamp();
        t_shadow();
        t_sync_in();
        t_stop();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule